// File: doc/BRIEF.md
# Paged register bank decoder

This block is the register access front end of a peripheral whose registers are grouped into pages of 256 bytes. A serial slave in front of it loads a local byte pointer, then strobes writes and reads. A current-page register lives at local address 0xFF. That address reaches the page register from every page. Every other local address selects the register whose 16-bit index is the current page in the upper byte and the local address in the lower byte.

The pointer steps after every byte, so multi-byte transfers fill or drain consecutive registers. A 16-bit quantity is sent high byte first, and its high byte lands at the lower address. The bank implements pages 0x00, 0x02, 0x09, 0x11 and 0x12. Any other page reads as zero and drops writes. The host does bit set and clear as read-modify-write, so there are no atomic operations.

Top module: `pgreg_bank`

## Requirements
- R1: After reset the current page is 0x00, the pointer is 0x00 and every stored register reads 0x00.
- R2: A write while the pointer is 0xFF loads the current page with the write data, whatever page was selected. No other write changes the page.
- R3: While the pointer is 0xFF, rdata_o returns the current page.
- R4: idx_o is the current page in bits 15:8 and the pointer in bits 7:0. A read or write at a pointer other than 0xFF accesses the register with that index.
- R5: ptr_load_i loads the pointer from addr_i on the next edge. In a cycle where ptr_load_i is high, wr_i and rd_i are ignored.
- R6: Each accepted write or read steps the pointer by one. From 0xFE or from 0xFF the pointer steps to 0x00, so a burst never reaches the page register.
- R7: Two consecutive writes of a 16-bit value, high byte first, put the high byte at the lower address and the low byte at the next address.
- R8: A burst of 128 reads that starts at address 0x00 of a page returns the 128 stored bytes in address order.
- R9: The five implemented pages keep separate storage. A write to one page leaves the same address in the other pages unchanged.
- R10: While an unimplemented page is selected, data addresses read 0x00 and writes have no effect.
- R11: Registers are written on the clock edge. The new value is visible on rdata_o, with no added latency, as soon as the pointer addresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_load_i | input | 1 | Load the local pointer from addr_i |
| addr_i | input | 8 | Local address to load into the pointer |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe, one byte consumed per cycle |
| rdata_o | output | 8 | Byte at the current pointer (combinational) |
| page_o | output | 8 | Current page |
| idx_o | output | 16 | Full register index {page, pointer} |

## Verification
The assertions check several rules on every cycle:
- the pointer loads and steps, including the wrap at 0xFE and 0xFF;
- a write at 0xFF loads the page, and no other access changes it;
- rdata_o returns the page while the pointer is 0xFF;
- rdata_o is zero on unimplemented pages.

Storage behaviour needs the bench's scenarios, because data must be written and read back later:
- separation between pages;
- the byte order of a 16-bit value;
- the order of a 128-byte burst;
- the effect of a write that arrives together with a pointer load.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 2 * ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam addr_t PAGE_SEL_ADDR  = '1;
  localparam addr_t LAST_DATA_ADDR = PAGE_SEL_ADDR - addr_t'(1);

  // Full register index: page in the upper half, local address below.
  function automatic idx_t reg_index(input addr_t page, input addr_t addr);
    return {page, addr};
  endfunction

  // Pointer after one byte: the page-select slot is never reached by stepping.
  function automatic addr_t next_addr(input addr_t a);
    if (a >= LAST_DATA_ADDR) return '0;
    return a + addr_t'(1);
  endfunction
endpackage

// File: rtl/pgreg_ptr.sv
module pgreg_ptr
  import pgreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  addr_t load_addr_i,
  input  logic  step_i,
  output addr_t ptr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_o <= '0;
    else if (load_i) ptr_o <= load_addr_i;
    else if (step_i) ptr_o <= next_addr(ptr_o);
  end
endmodule

// File: rtl/pgreg_pagesel.sv
module pgreg_pagesel
  import pgreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_i,
  input  data_t wdata_i,
  output addr_t page_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    page_o <= '0;
    else if (we_i) page_o <= addr_t'(wdata_i);
  end
endmodule

// File: rtl/pgreg_file.sv
module pgreg_file
  import pgreg_pkg::*;
#(
  parameter int NUM_PAGES = 5,
  parameter logic [NUM_PAGES*ADDR_W-1:0] PAGE_LIST = {8'h12, 8'h11, 8'h09, 8'h02, 8'h00}
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_i,
  input  addr_t page_i,
  input  addr_t addr_i,
  input  data_t wdata_i,
  output data_t rdata_o
);
  localparam int SLOTS = (1 << ADDR_W) - 1;

  data_t rd_vec [NUM_PAGES];
  logic  data_slot;

  assign data_slot = (addr_i != PAGE_SEL_ADDR);

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    localparam addr_t PID = PAGE_LIST[g*ADDR_W +: ADDR_W];
    data_t mem [SLOTS];
    logic  sel;

    assign sel = (page_i == PID) && data_slot;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < SLOTS; k++) mem[k] <= '0;
      end else if (we_i && sel) begin
        mem[addr_i] <= wdata_i;
      end
    end

    assign rd_vec[g] = sel ? mem[addr_i] : '0;
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_PAGES; g++) rdata_o = rdata_o | rd_vec[g];
  end
endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank
  import pgreg_pkg::*;
#(
  parameter int NUM_PAGES = 5,
  parameter logic [NUM_PAGES*ADDR_W-1:0] PAGE_LIST = {8'h12, 8'h11, 8'h09, 8'h02, 8'h00}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] page_o,
  output logic [IDX_W-1:0]  idx_o
);
  addr_t ptr;
  addr_t page;
  data_t file_rdata;

  // Named internal events
  logic acc_ev;      // accepted byte (read or write)
  logic wr_ev;       // accepted write
  logic page_wr_ev;  // write landing in the page-select slot
  logic reg_wr_ev;   // write landing in a data register
  logic at_sel;

  assign at_sel     = (ptr == PAGE_SEL_ADDR);
  assign acc_ev     = (wr_i | rd_i) & ~ptr_load_i;
  assign wr_ev      = wr_i & ~ptr_load_i;
  assign page_wr_ev = wr_ev & at_sel;
  assign reg_wr_ev  = wr_ev & ~at_sel;

  pgreg_ptr u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ptr_load_i),
    .load_addr_i (addr_i),
    .step_i      (acc_ev),
    .ptr_o       (ptr)
  );

  pgreg_pagesel u_pagesel (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (page_wr_ev),
    .wdata_i (wdata_i),
    .page_o  (page)
  );

  pgreg_file #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_LIST (PAGE_LIST)
  ) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_wr_ev),
    .page_i  (page),
    .addr_i  (ptr),
    .wdata_i (wdata_i),
    .rdata_o (file_rdata)
  );

  assign rdata_o = at_sel ? data_t'(page) : file_rdata;
  assign page_o  = page;
  assign idx_o   = reg_index(page, ptr);
endmodule

// File: rtl/pgreg_bank_chk.sv
module pgreg_bank_chk
  import pgreg_pkg::*;
#(
  parameter int NUM_PAGES = 5,
  parameter logic [NUM_PAGES*ADDR_W-1:0] PAGE_LIST = {8'h12, 8'h11, 8'h09, 8'h02, 8'h00}
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ptr_load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ADDR_W-1:0] page_o,
  input logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] cptr;
  logic              impl;
  logic              acc;

  assign cptr = idx_o[ADDR_W-1:0];
  assign acc  = (wr_i || rd_i) && !ptr_load_i;

  always_comb begin
    impl = 1'b0;
    for (int g = 0; g < NUM_PAGES; g++)
      if (PAGE_LIST[g*ADDR_W +: ADDR_W] == page_o) impl = 1'b1;
  end

  // R5
  a_r5_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load_i |=> cptr == $past(addr_i));

  // R6
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cptr < 8'hFE) |=> cptr == $past(cptr) + 8'd1);

  // R6
  a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cptr >= 8'hFE) |=> cptr == 8'h00);

  // R2
  a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && !ptr_load_i && (cptr == 8'hFF) |=> page_o == $past(wdata_i));

  // R2
  a_r2_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && !ptr_load_i && (cptr == 8'hFF)) |=> $stable(page_o));

  // R3
  a_r3_page_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cptr == 8'hFF) |-> rdata_o == page_o);

  // R10
  a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !impl && (cptr != 8'hFF) |-> rdata_o == 8'h00);
endmodule

bind pgreg_bank pgreg_bank_chk #(
  .NUM_PAGES (NUM_PAGES),
  .PAGE_LIST (PAGE_LIST)
) u_chk (.*);

// File: tb/pgreg_bank_tb.sv
module pgreg_bank_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ptr_load_i = 0;
  logic [7:0]  addr_i = 0;
  logic        wr_i = 0;
  logic [7:0]  wdata_i = 0;
  logic        rd_i = 0;
  logic [7:0]  rdata_o;
  logic [7:0]  page_o;
  logic [15:0] idx_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] model [int];
  logic [7:0] bptr = 0;
  logic [7:0] bpage = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  pgreg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_load_i(ptr_load_i), .addr_i(addr_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .page_o(page_o), .idx_o(idx_o)
  );

  function automatic bit is_impl(input logic [7:0] p);
    return (p == 8'h00) || (p == 8'h02) || (p == 8'h09) || (p == 8'h11) || (p == 8'h12);
  endfunction

  function automatic logic [7:0] step(input logic [7:0] p);
    if (p == 8'hFE || p == 8'hFF) return 8'h00;
    return p + 8'd1;
  endfunction

  function automatic logic [7:0] expect_at(input logic [7:0] p);
    int key;
    if (p == 8'hFF) return bpage;
    if (!is_impl(bpage)) return 8'h00;
    key = bpage * 256 + p;
    if (model.exists(key)) return model[key];
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc_clear();
    @(posedge clk); #1;
    ptr_load_i = 0; wr_i = 0; rd_i = 0;
  endtask

  task automatic t_idle();
    cyc_clear();
  endtask

  task automatic t_load(input logic [7:0] a);
    cyc_clear();
    ptr_load_i = 1; addr_i = a;
    bptr = a;
  endtask

  task automatic t_wr(input logic [7:0] d);
    cyc_clear();
    wr_i = 1; wdata_i = d;
    if (bptr == 8'hFF) bpage = d;
    else if (is_impl(bpage)) model[bpage * 256 + bptr] = d;
    bptr = step(bptr);
  endtask

  task automatic t_rd(input string tag);
    cyc_clear();
    exp_q.push_back(expect_at(bptr));
    tag_q.push_back(tag);
    rd_i = 1;
    bptr = step(bptr);
  endtask

  task automatic set_page(input logic [7:0] p);
    t_load(8'hFF);
    t_wr(p);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_i && !ptr_load_i) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read actual=%h expected=none", rdata_o);
      end else begin
        chk(tag_q.pop_front(), {8'h00, rdata_o}, {8'h00, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 page after reset", {8'h00, page_o}, 16'h0000);
    chk("R1 index after reset", idx_o, 16'h0000);
    chk("R1 data after reset", {8'h00, rdata_o}, 16'h0000);

    // R3: page-select slot reads the page
    t_load(8'hFF); t_rd("R3 page read at reset");

    // R7 / R11: 16-bit value, high byte first
    t_load(8'h10); t_wr(8'hA5); t_wr(8'h5A);
    t_load(8'h10); t_rd("R7 high byte at lower address"); t_rd("R7 low byte at next address");
    t_load(8'h20); t_wr(8'hC3); t_load(8'h20); t_rd("R11 written byte visible");

    // R2: page select from page 0, then from page 2
    set_page(8'h02); t_idle(); @(negedge clk);
    chk("R2 page loaded", {8'h00, page_o}, 16'h0002);
    t_load(8'hFF); t_rd("R3 page read on page 2");
    t_load(8'h10); t_wr(8'h33);
    t_load(8'h10); t_idle(); @(negedge clk);
    chk("R4 index on page 2", idx_o, 16'h0210);
    t_rd("R9 page 2 own value");
    set_page(8'h00);
    t_load(8'h10); t_rd("R9 page 0 unchanged by page 2 write");

    // R9: pages 0x11 and 0x12
    set_page(8'h11); t_load(8'h05); t_wr(8'h71);
    set_page(8'h12); t_load(8'h05); t_wr(8'h72);
    t_load(8'h05); t_rd("R9 page 0x12 value");
    set_page(8'h11); t_load(8'h05); t_rd("R9 page 0x11 value");

    // R8: 128-byte burst on page 0x09
    set_page(8'h09); t_load(8'h00);
    for (int i = 0; i < 128; i++) t_wr(8'(i) ^ 8'h3C);
    t_load(8'h00);
    for (int i = 0; i < 128; i++) t_rd("R8 burst read byte");
    t_idle(); @(negedge clk);
    chk("R8 pointer after burst", idx_o, 16'h0980);

    // R6: wrap from 0xFE to 0x00 skipping the page slot
    t_load(8'hFD); t_wr(8'h01); t_wr(8'h02); t_wr(8'h03);
    t_idle(); @(negedge clk);
    chk("R6 wrapped pointer", idx_o, 16'h0901);
    chk("R6 page not touched by burst", {8'h00, page_o}, 16'h0009);
    t_load(8'hFD); t_rd("R6 byte at FD"); t_rd("R6 byte at FE"); t_rd("R6 byte at 00");
    t_load(8'hFF); t_rd("R6 page slot from FF"); t_idle(); @(negedge clk);
    chk("R6 step from FF wraps", idx_o, 16'h0900);

    // R10: unimplemented page
    set_page(8'h05); t_load(8'h20); t_wr(8'h77);
    t_load(8'h20); t_idle(); @(negedge clk);
    chk("R4 index on page 5", idx_o, 16'h0520);
    t_rd("R10 unimplemented reads zero");
    set_page(8'h00); t_load(8'h20); t_rd("R10 page 0 untouched by page 5 write");

    // R5: load and write in one cycle, write ignored
    t_load(8'h40); t_wr(8'h11);
    cyc_clear();
    ptr_load_i = 1; addr_i = 8'h41; wr_i = 1; wdata_i = 8'h99;
    bptr = 8'h41;
    t_idle(); @(negedge clk);
    chk("R5 pointer loaded", idx_o, 16'h0041);
    t_rd("R5 write with load ignored");
    t_load(8'h40); t_rd("R5 earlier write kept");

    t_idle(); t_idle();
    chk("scoreboard drained", 16'(exp_q.size()), 16'h0000);
    finish_up();
  end
endmodule